// File: doc/BRIEF.md
# Saturating Run-Time Q-Format Multiply/Add Unit

This block is a shared 16-bit signed arithmetic stage for datapaths where the binary point moves from one computation step to the next. Each request carries two operands and a fractional-bit count for each. A multiply also carries the fractional-bit count wanted in the result. The unit adds, subtracts or multiplies. It realigns a product to the requested scale by a variable arithmetic shift, and it clamps any result that does not fit to the nearest representable limit.

Operands narrower than the internal word are padded with zeros on the right before use. Every fractional count given at the ports refers to the padded word. A request that cannot be carried out is reported on a dedicated error output and produces a zero result. Such a request is one with mismatched scales on an add or subtract, an impossible realignment on a multiply, or an unused operation code. Each request is answered one clock after it is presented.

Top module: `qfx_mac_unit`

## Requirements
- R1: While reset is asserted, out_valid, result, sat and cfg_err are all zero.
- R2: out_valid is high in exactly the cycle after a cycle with in_valid high and low otherwise. When in_valid is low, result, sat and cfg_err keep their values.
- R3: op_sel = 0 returns a + b. If the true sum lies above 32767 or below -32768, result is clamped to that limit and sat is 1. Otherwise sat is 0.
- R4: op_sel = 1 returns a - b, clamped the same way as R3, with sat marking a clamp.
- R5: For op_sel 0 or 1, if the two operand fractional counts differ, cfg_err is 1, result is 0 and sat is 0.
- R6: op_sel = 2 returns floor(a * b / 2^m), where m = fa + fb - fc. This truncates toward negative infinity with no rounding. A Q10.6 by Q5.11 product into Q6.10 uses m = 7.
- R7: When the shifted product of R6 does not fit in 16 signed bits, result is 32767 for a positive product or -32768 for a negative one, and sat is 1.
- R8: cfg_err is 1 and result and sat are 0 in two cases. The first is a multiply whose m is below 0 or above 16. The second is any request in which an operand fractional count exceeds 16, counting fc for multiplies only.
- R9: op_sel = 3 is reserved. It gives cfg_err = 1, result 0 and sat 0.
- R10: With an operand width DIN_W below 16, each operand is widened as {operand, zeros}. A 12-bit value v therefore takes part as v * 16.
- R11: For add and subtract, fc has no effect on result, sat or cfg_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | 0 add, 1 subtract, 2 multiply, 3 reserved |
| opa | input | DIN_W | Operand a, two's complement |
| opb | input | DIN_W | Operand b, two's complement |
| fa | input | FW | Fractional bits of a (widened word) |
| fb | input | FW | Fractional bits of b (widened word) |
| fc | input | FW | Fractional bits wanted in a product |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | W | Result word, two's complement |
| sat | output | 1 | Result was clamped |
| cfg_err | output | 1 | Request could not be carried out; result forced to zero |

## Verification
The bench builds two copies of the unit side by side, both with W = 16. The first has DIN_W = 16, so the extremes of the word can be driven directly: -32768, limit products and m = 16. The second has DIN_W = 12, which brings the zero-padding of narrow operands within reach. That copy is checked through sums and products whose values only come out right if the padding sits below the least significant bit.

// File: rtl/qfx_pkg.sv
package qfx_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_RSV = 2'd3
  } qfx_op_e;

endpackage

// File: rtl/qfx_widen.sv
module qfx_widen #(
  parameter int DIN_W = 16,
  parameter int W     = 16
) (
  input  logic [DIN_W-1:0] din,
  output logic [W-1:0]     dout
);

  localparam int PAD = W - DIN_W;

  generate
    if (PAD == 0) begin : g_pass
      assign dout = din;
    end else begin : g_pad
      // narrow operand sits in the top bits; new low bits are zero
      assign dout = {din, {PAD{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/qfx_addsub.sv
module qfx_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y,
  output logic         ovf
);

  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  // one guard bit; a true sum needs at most W+1 bits
  function automatic logic [W:0] ext_sum(input logic [W-1:0] x,
                                          input logic [W-1:0] z,
                                          input logic         minus);
    logic [W:0] xe, ze;
    xe = {x[W-1], x};
    ze = {z[W-1], z};
    return minus ? (xe - ze) : (xe + ze);
  endfunction

  logic [W:0] wide;

  always_comb begin
    wide = ext_sum(a, b, sub);
    ovf  = wide[W] ^ wide[W-1];
    if (ovf) y = wide[W] ? NEG_LIM : POS_LIM;
    else     y = wide[W-1:0];
  end

endmodule

// File: rtl/qfx_mul_align.sv
module qfx_mul_align #(
  parameter int W  = 16,
  parameter int FW = 5
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [FW-1:0] fa,
  input  logic [FW-1:0] fb,
  input  logic [FW-1:0] fc,
  output logic [W-1:0]  y,
  output logic          ovf,
  output logic          shift_bad
);

  localparam int PW = 2 * W;
  localparam int MW = FW + 2;
  localparam logic signed [MW-1:0] M_MAX = MW'(W);
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  // right-shift distance that moves the product to the requested scale
  function automatic logic signed [MW-1:0] shift_dist(input logic [FW-1:0] f1,
                                                      input logic [FW-1:0] f2,
                                                      input logic [FW-1:0] f3);
    return $signed({2'b00, f1}) + $signed({2'b00, f2}) - $signed({2'b00, f3});
  endfunction

  // true when the bits above the kept word are not a pure sign extension
  function automatic logic lost_high(input logic [PW-1:0] v);
    logic [PW-W:0] top;
    top = v[PW-1:W-1];
    return !((&top) || !(|top));
  endfunction

  logic signed [W-1:0]  sa, sb;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shifted;
  logic signed [MW-1:0] m;
  logic        [FW:0]   sh;

  always_comb begin
    sa        = $signed(a);
    sb        = $signed(b);
    prod      = sa * sb;
    m         = shift_dist(fa, fb, fc);
    shift_bad = m[MW-1] || (m > M_MAX);
    sh        = shift_bad ? '0 : m[FW:0];
    shifted   = prod >>> sh;
    ovf       = lost_high(shifted);
    if (ovf) y = shifted[PW-1] ? NEG_LIM : POS_LIM;
    else     y = shifted[W-1:0];
  end

endmodule

// File: rtl/qfx_mac_unit.sv
module qfx_mac_unit
  import qfx_pkg::*;
#(
  parameter int W     = 16,
  parameter int DIN_W = 16,
  parameter int FW    = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       op_sel,
  input  logic [DIN_W-1:0] opa,
  input  logic [DIN_W-1:0] opb,
  input  logic [FW-1:0]    fa,
  input  logic [FW-1:0]    fb,
  input  logic [FW-1:0]    fc,
  output logic             out_valid,
  output logic [W-1:0]     result,
  output logic             sat,
  output logic             cfg_err
);

  localparam logic [FW-1:0] F_MAX = FW'(W);

  qfx_op_e     op;
  logic [W-1:0] a_w, b_w;
  logic [W-1:0] as_y, mu_y;
  logic        w_add_ovf;
  logic        w_mul_ovf;
  logic        w_shift_bad;
  logic        w_cfg_bad;
  logic [W-1:0] nx_res;
  logic        nx_sat;

  assign op = qfx_op_e'(op_sel);

  qfx_widen #(.DIN_W(DIN_W), .W(W)) u_wid_a (.din(opa), .dout(a_w));
  qfx_widen #(.DIN_W(DIN_W), .W(W)) u_wid_b (.din(opb), .dout(b_w));

  qfx_addsub #(.W(W)) u_addsub (
    .a   (a_w),
    .b   (b_w),
    .sub (op == OP_SUB),
    .y   (as_y),
    .ovf (w_add_ovf)
  );

  qfx_mul_align #(.W(W), .FW(FW)) u_mul (
    .a         (a_w),
    .b         (b_w),
    .fa        (fa),
    .fb        (fb),
    .fc        (fc),
    .y         (mu_y),
    .ovf       (w_mul_ovf),
    .shift_bad (w_shift_bad)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB: w_cfg_bad = (fa != fb) || (fa > F_MAX) || (fb > F_MAX);
      OP_MUL:         w_cfg_bad = w_shift_bad || (fa > F_MAX) || (fb > F_MAX) || (fc > F_MAX);
      default:        w_cfg_bad = 1'b1;
    endcase
  end

  always_comb begin
    if (w_cfg_bad) begin
      nx_res = '0;
      nx_sat = 1'b0;
    end else if (op == OP_MUL) begin
      nx_res = mu_y;
      nx_sat = w_mul_ovf;
    end else begin
      nx_res = as_y;
      nx_sat = w_add_ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat       <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= nx_res;
        sat     <= nx_sat;
        cfg_err <= w_cfg_bad;
      end
    end
  end

endmodule

// File: rtl/qfx_mac_unit_chk.sv
module qfx_mac_unit_chk #(
  parameter int W     = 16,
  parameter int DIN_W = 16,
  parameter int FW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       op_sel,
  input logic [DIN_W-1:0] opa,
  input logic [DIN_W-1:0] opb,
  input logic             out_valid,
  input logic [W-1:0]     result,
  input logic             sat,
  input logic             cfg_err,
  input logic             w_add_ovf,
  input logic             w_mul_ovf,
  input logic             w_cfg_bad
);

  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(sat) && $stable(cfg_err)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd0 && !w_cfg_bad && (opa[DIN_W-1] != opb[DIN_W-1])) |=> !sat);

  p_addsub_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel[1] == 1'b0 && !w_cfg_bad && w_add_ovf) |=> sat);

  p_mul_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd2 && !w_cfg_bad && w_mul_ovf) |=> sat);

  p_sat_at_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sat |-> (result == POS_LIM || result == NEG_LIM));

  p_cfg_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (result == '0 && !sat));

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd3) |=> cfg_err);

endmodule

bind qfx_mac_unit qfx_mac_unit_chk #(.W(W), .DIN_W(DIN_W), .FW(FW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_sel    (op_sel),
  .opa       (opa),
  .opb       (opb),
  .out_valid (out_valid),
  .result    (result),
  .sat       (sat),
  .cfg_err   (cfg_err),
  .w_add_ovf (w_add_ovf),
  .w_mul_ovf (w_mul_ovf),
  .w_cfg_bad (w_cfg_bad)
);

// File: tb/qfx_mac_unit_bench.sv
`timescale 1ns/1ps
module qfx_mac_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'd0;
  logic [15:0] opa = '0, opb = '0;
  logic [11:0] na = '0, nb = '0;
  logic [4:0]  fa = '0, fb = '0, fc = '0;

  logic        w_vld, w_sat, w_err;
  logic [15:0] w_res;
  logic        n_vld, n_sat, n_err;
  logic [15:0] n_res;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  qfx_mac_unit #(.W(16), .DIN_W(16)) u_qfx_mac_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opa(opa), .opb(opb), .fa(fa), .fb(fb), .fc(fc),
    .out_valid(w_vld), .result(w_res), .sat(w_sat), .cfg_err(w_err));

  qfx_mac_unit #(.W(16), .DIN_W(12)) u_narrow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opa(na), .opb(nb), .fa(fa), .fb(fb), .fc(fc),
    .out_valid(n_vld), .result(n_res), .sat(n_sat), .cfg_err(n_err));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // reference: plain integer arithmetic with explicit floor division
  task automatic model(input int op, input int a, input int b, input int f1, input int f2,
                       input int f3, output int r, output int s, output int e);
    longint v, d, q;
    int m;
    r = 0; s = 0; e = 0;
    if (op == 3) begin
      e = 1;
      return;
    end
    if (op < 2) begin
      if (f1 != f2 || f1 > 16 || f2 > 16) begin e = 1; return; end
      v = (op == 0) ? longint'(a) + b : longint'(a) - b;
    end else begin
      m = f1 + f2 - f3;
      if (f1 > 16 || f2 > 16 || f3 > 16 || m < 0 || m > 16) begin e = 1; return; end
      v = longint'(a) * longint'(b);
      d = longint'(1) << m;
      q = v / d;
      if (v < 0 && (v % d) != 0) q = q - 1;
      v = q;
    end
    if (v > 32767)       begin r = 32767;  s = 1; end
    else if (v < -32768) begin r = -32768; s = 1; end
    else                 r = int'(v);
  endtask

  task automatic drive(input int op, input int a, input int b, input int xa, input int xb,
                       input int f1, input int f2, input int f3);
    @(negedge clk);
    op_sel = 2'(op);
    opa = 16'(a); opb = 16'(b);
    na = 12'(xa); nb = 12'(xb);
    fa = 5'(f1); fb = 5'(f2); fc = 5'(f3);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_op(input string tag, input int op, input int a, input int b,
                       input int f1, input int f2, input int f3);
    int r, s, e;
    model(op, a, b, f1, f2, f3, r, s, e);
    drive(op, a, b, 0, 0, f1, f2, f3);
    chk(tag, "out_valid", int'(w_vld), 1);
    chk(tag, "result", int'($signed(w_res)), r);
    chk(tag, "sat", int'(w_sat), s);
    chk(tag, "cfg_err", int'(w_err), e);
  endtask

  task automatic narrow_op(input string tag, input int op, input int xa, input int xb,
                           input int f1, input int f2, input int f3);
    logic [15:0] ta, tb;
    int r, s, e;
    ta = {12'(xa), 4'b0000};
    tb = {12'(xb), 4'b0000};
    model(op, int'($signed(ta)), int'($signed(tb)), f1, f2, f3, r, s, e);
    drive(op, 0, 0, xa, xb, f1, f2, f3);
    chk(tag, "narrow result", int'($signed(n_res)), r);
    chk(tag, "narrow sat", int'(n_sat), s);
    chk(tag, "narrow cfg_err", int'(n_err), e);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "out_valid", int'(w_vld), 0);
    chk("R1", "result", int'(w_res), 0);
    chk("R1", "sat", int'(w_sat), 0);
    chk("R1", "cfg_err", int'(w_err), 0);
    chk("R1", "narrow result", int'(n_res), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_add;
    do_op("R3", 0, 1000, 2345, 8, 8, 8);
    do_op("R3", 0, -700, 250, 4, 4, 4);
    do_op("R3", 0, 30000, 10000, 10, 10, 10);
    do_op("R3", 0, -30000, -10000, 10, 10, 10);
    do_op("R3", 0, 32767, -32768, 0, 0, 0);
  endtask

  task automatic t_sub;
    do_op("R4", 1, 100, 300, 6, 6, 6);
    do_op("R4", 1, -32768, 1, 0, 0, 0);
    do_op("R4", 1, 0, -32768, 3, 3, 3);
    do_op("R4", 1, -32768, -32768, 16, 16, 16);
  endtask

  task automatic t_mismatch;
    do_op("R5", 0, 1000, 1000, 6, 7, 6);
    do_op("R5", 1, 30000, -30000, 12, 2, 12);
  endtask

  task automatic t_fc_free;
    do_op("R11", 0, 1234, 4321, 5, 5, 0);
    do_op("R11", 0, 1234, 4321, 5, 5, 31);
    do_op("R11", 1, -5000, 2000, 9, 9, 20);
  endtask

  task automatic t_mul;
    do_op("R6", 2, 224, 2560, 6, 11, 10);
    do_op("R6", 2, -3, 1, 1, 0, 0);
    do_op("R6", 2, -224, 2560, 6, 11, 10);
    do_op("R6", 2, 20000, 20000, 15, 15, 15);
    do_op("R6", 2, -32768, -32768, 8, 8, 0);
    do_op("R6", 2, 77, -5, 2, 2, 4);
  endtask

  task automatic t_mul_sat;
    do_op("R7", 2, 32767, 32767, 0, 0, 0);
    do_op("R7", 2, 32767, -32768, 0, 0, 0);
    do_op("R7", 2, -32768, -32768, 8, 8, 1);
    do_op("R7", 2, 300, -300, 2, 2, 3);
  endtask

  task automatic t_cfg;
    do_op("R8", 2, 100, 100, 0, 0, 1);
    do_op("R8", 2, 100, 100, 10, 10, 2);
    do_op("R8", 0, 100, 100, 17, 17, 0);
    do_op("R8", 2, 100, 100, 17, 0, 16);
  endtask

  task automatic t_rsv;
    do_op("R9", 3, 5, 6, 0, 0, 0);
  endtask

  task automatic t_latency;
    do_op("R2", 0, 11, 22, 0, 0, 0);
    @(negedge clk);
    chk("R2", "out_valid drops", int'(w_vld), 0);
    opa = 16'd999; opb = 16'd1; op_sel = 2'd2;
    @(negedge clk);
    chk("R2", "result held", int'($signed(w_res)), 33);
    chk("R2", "out_valid idle", int'(w_vld), 0);
  endtask

  task automatic t_narrow;
    narrow_op("R10", 0, 1, 2, 0, 0, 0);
    narrow_op("R10", 0, 12'h7FF, 0, 4, 4, 4);
    narrow_op("R10", 2, 3, 5, 4, 4, 4);
    narrow_op("R10", 2, -7, 9, 8, 8, 8);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_mismatch();
    t_fc_free();
    t_mul();
    t_mul_sat();
    t_cfg();
    t_rsv();
    t_latency();
    t_narrow();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R2: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule